// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block changes the multiplier of a phase-locked loop without ever exposing a half-configured clock downstream. A single start pulse carries the new encoded multiplier word. The sequencer drives a simple register port toward the PLL's control and status registers. It reads the control word and then writes it back with the loop powered down and isolated. Next it loads the multiplier, then it loads the pre/post divider word that selects divide-by-one on both sides. After that it powers the loop up, keeping every other control bit as it was.

After power-up the sequencer polls the lock flag in the status register. The clock-output enable is set only once lock is seen. If the programmable number of polls passes without lock, the run ends with an error, and the loop stays powered but its output remains disabled. One done pulse closes every run, and an error pulse goes with it when the run failed. A start that arrives during a run is ignored.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset the block is idle: busy_o, done_o, error_o, reg_we_o and reg_re_o are all low.
- R2: A start accepted from idle first reads the control register (address A_CTRL, default 1). It then writes that register with bit 0 (power-down) set and bits 1 (bypass), 2 (direct-in), 3 (direct-out) and 4 (clock enable) cleared, all other bits preserved.
- R3: After the isolation write, the multiplier word given with start is written to the multiplier register (A_MDIV, default 2). The next write puts 0x00302062 into the divider register (A_NPDIV, default 3).
- R4: After the divider write, the control register is written with the isolation value but with bit 0 cleared.
- R5: The sequencer then polls bit 0 of the status register (A_STAT, default 0). On the first poll that shows lock, it writes the control register with the power-up value plus bit 4 set. The cycle after that write it raises done_o for exactly one cycle with error_o low.
- R6: If lock_limit_i consecutive polls (lock_limit_i at least 1) all show no lock, done_o and error_o rise together for one cycle. No write with bit 4 set is issued.
- R7: A start that arrives while busy_o is high is ignored: the running sequence continues with its original multiplier, and no second sequence follows.
- R8: Read data is taken on the cycle after the read strobe. Read and write strobes are never high in the same cycle.
- R9: busy_o is high from the cycle after a start is accepted through the done cycle, and a new start is accepted on the first idle cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to reprogram, sampled only when idle |
| mult_i | input | DATA_W | Encoded multiplier word captured with start |
| lock_limit_i | input | LIMIT_W | Number of failed lock polls that ends the run in error |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| error_o | output | 1 | One-cycle lock timeout flag, coincides with done_o |
| reg_we_o | output | 1 | Register write strobe |
| reg_re_o | output | 1 | Register read strobe |
| reg_addr_o | output | ADDR_W | Register address |
| reg_wdata_o | output | DATA_W | Register write data |
| reg_rdata_i | input | DATA_W | Read data, valid the cycle after reg_re_o |

## Verification
The lock timeout boundary gets the closest attention. The bench runs with lock arriving on the last allowed poll and again on the poll just past it, because an off-by-one counter would flip one of those two outcomes. Control words with bypass, direct and upper bits already set check that the read-modify-write clears exactly the isolation bits: a design that wrote a constant, or forgot a bit, would miscompare on the first write. A start pulsed mid-run with a different multiplier catches a design that restarts or reloads. A failed run is followed by a look at the modelled control register, to confirm that the clock enable never reached the PLL.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;
  // Control register bit positions (decoded by the PLL).
  localparam int unsigned CB_PWRDN  = 0;
  localparam int unsigned CB_BYPASS = 1;
  localparam int unsigned CB_DIRIN  = 2;
  localparam int unsigned CB_DIROUT = 3;
  localparam int unsigned CB_CLKEN  = 4;
  // Status register lock flag.
  localparam int unsigned SB_LOCK   = 0;
  // Divider word selecting divide-by-one for pre and post dividers.
  localparam logic [31:0] DIV_UNITY = 32'h0030_2062;

  typedef enum logic [3:0] {
    S_IDLE, S_RDCTL, S_CAPT, S_ISO, S_MDIV, S_NPDIV,
    S_PWRUP, S_POLL, S_CHK, S_ENABLE, S_DONE, S_FAIL
  } seq_state_e;
endpackage

// File: rtl/pllseq_ctrl_edit.sv
module pllseq_ctrl_edit
  import pllseq_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] raw_i,
  output logic [DATA_W-1:0] iso_o,
  output logic [DATA_W-1:0] up_o,
  output logic [DATA_W-1:0] en_o
);
  always_comb begin
    iso_o             = raw_i;
    iso_o[CB_PWRDN]   = 1'b1;
    iso_o[CB_BYPASS]  = 1'b0;
    iso_o[CB_DIRIN]   = 1'b0;
    iso_o[CB_DIROUT]  = 1'b0;
    iso_o[CB_CLKEN]   = 1'b0;
    up_o              = iso_o;
    up_o[CB_PWRDN]    = 1'b0;
    en_o              = up_o;
    en_o[CB_CLKEN]    = 1'b1;
  end
endmodule

// File: rtl/pllseq_lock_timer.sv
module pllseq_lock_timer #(
  parameter int unsigned LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear_i,
  input  logic               bump_i,
  input  logic [LIMIT_W-1:0] limit_i,
  output logic               expired_o
);
  localparam int unsigned CW = LIMIT_W + 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = clear_i | bump_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)
      cnt_d = '0;
    else if (bump_i && (cnt_q != {CW{1'b1}}))
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  // Expires when the poll now failing would be the limit-th failure.
  assign expired_o = ((cnt_q + 1'b1) >= {1'b0, limit_i});
endmodule

// File: rtl/pllseq_fsm.sv
module pllseq_fsm
  import pllseq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] A_STAT  = 0,
  parameter logic [ADDR_W-1:0] A_CTRL  = 1,
  parameter logic [ADDR_W-1:0] A_MDIV  = 2,
  parameter logic [ADDR_W-1:0] A_NPDIV = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] mult_i,
  input  logic              expired_i,
  input  logic [DATA_W-1:0] iso_i,
  input  logic [DATA_W-1:0] up_i,
  input  logic [DATA_W-1:0] en_i,
  output logic [DATA_W-1:0] ctrl_raw_o,
  output logic              tmr_clear_o,
  output logic              tmr_bump_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  seq_state_e        state_q, state_d;
  logic [DATA_W-1:0] mult_q, ctrl_q;
  logic              accept, capture, locked;

  assign accept  = (state_q == S_IDLE) && start_i;
  assign capture = (state_q == S_CAPT);
  assign locked  = reg_rdata_i[SB_LOCK];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:   if (start_i) state_d = S_RDCTL;
      S_RDCTL:  state_d = S_CAPT;
      S_CAPT:   state_d = S_ISO;
      S_ISO:    state_d = S_MDIV;
      S_MDIV:   state_d = S_NPDIV;
      S_NPDIV:  state_d = S_PWRUP;
      S_PWRUP:  state_d = S_POLL;
      S_POLL:   state_d = S_CHK;
      S_CHK:    if (locked)         state_d = S_ENABLE;
                else if (expired_i) state_d = S_FAIL;
                else                state_d = S_POLL;
      S_ENABLE: state_d = S_DONE;
      S_DONE:   state_d = S_IDLE;
      S_FAIL:   state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mult_q <= '0;
    else if (accept) mult_q <= mult_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (capture) ctrl_q <= reg_rdata_i;
  end

  assign ctrl_raw_o  = ctrl_q;
  assign tmr_clear_o = (state_q == S_PWRUP);
  assign tmr_bump_o  = (state_q == S_CHK) && !locked;

  always_comb begin
    reg_we_o    = 1'b0;
    reg_re_o    = 1'b0;
    reg_addr_o  = A_STAT;
    reg_wdata_o = '0;
    unique case (state_q)
      S_RDCTL:  begin reg_re_o = 1'b1; reg_addr_o = A_CTRL; end
      S_POLL:   begin reg_re_o = 1'b1; reg_addr_o = A_STAT; end
      S_ISO:    begin reg_we_o = 1'b1; reg_addr_o = A_CTRL;  reg_wdata_o = iso_i;  end
      S_MDIV:   begin reg_we_o = 1'b1; reg_addr_o = A_MDIV;  reg_wdata_o = mult_q; end
      S_NPDIV:  begin reg_we_o = 1'b1; reg_addr_o = A_NPDIV;
                      reg_wdata_o = DATA_W'(DIV_UNITY); end
      S_PWRUP:  begin reg_we_o = 1'b1; reg_addr_o = A_CTRL;  reg_wdata_o = up_i;   end
      S_ENABLE: begin reg_we_o = 1'b1; reg_addr_o = A_CTRL;  reg_wdata_o = en_i;   end
      default:  ;
    endcase
  end

  assign busy_o  = (state_q != S_IDLE);
  assign done_o  = (state_q == S_DONE) || (state_q == S_FAIL);
  assign error_o = (state_q == S_FAIL);

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we_o && reg_re_o));
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_err_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |-> done_o);
  assert_clken_after_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_o && (reg_addr_o == A_CTRL) && reg_wdata_o[CB_CLKEN]) |-> $past(reg_rdata_i[SB_LOCK]));
  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o && !done_o) |=> busy_o);
  assert_iso_pd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_o && (reg_addr_o == A_MDIV)) |-> $past(reg_we_o && reg_wdata_o[CB_PWRDN]));
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned LIMIT_W = 16,
  parameter logic [ADDR_W-1:0] A_STAT  = 0,
  parameter logic [ADDR_W-1:0] A_CTRL  = 1,
  parameter logic [ADDR_W-1:0] A_MDIV  = 2,
  parameter logic [ADDR_W-1:0] A_NPDIV = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [DATA_W-1:0]  mult_i,
  input  logic [LIMIT_W-1:0] lock_limit_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               error_o,
  output logic               reg_we_o,
  output logic               reg_re_o,
  output logic [ADDR_W-1:0]  reg_addr_o,
  output logic [DATA_W-1:0]  reg_wdata_o,
  input  logic [DATA_W-1:0]  reg_rdata_i
);
  logic [DATA_W-1:0] ctrl_raw, iso_w, up_w, en_w;
  logic              tmr_clear, tmr_bump, expired;

  pllseq_ctrl_edit #(.DATA_W(DATA_W)) u_edit (
    .raw_i(ctrl_raw), .iso_o(iso_w), .up_o(up_w), .en_o(en_w)
  );

  pllseq_lock_timer #(.LIMIT_W(LIMIT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear_i(tmr_clear), .bump_i(tmr_bump),
    .limit_i(lock_limit_i), .expired_o(expired)
  );

  pllseq_fsm #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .A_STAT(A_STAT), .A_CTRL(A_CTRL), .A_MDIV(A_MDIV), .A_NPDIV(A_NPDIV)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mult_i(mult_i),
    .expired_i(expired), .iso_i(iso_w), .up_i(up_w), .en_i(en_w),
    .ctrl_raw_o(ctrl_raw), .tmr_clear_o(tmr_clear), .tmr_bump_o(tmr_bump),
    .busy_o(busy_o), .done_o(done_o), .error_o(error_o),
    .reg_we_o(reg_we_o), .reg_re_o(reg_re_o), .reg_addr_o(reg_addr_o),
    .reg_wdata_o(reg_wdata_o), .reg_rdata_i(reg_rdata_i)
  );
endmodule

// File: tb/test_pll_reprog_seq.sv
module test_pll_reprog_seq;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 4;
  localparam int unsigned LW = 16;
  localparam logic [AW-1:0] AS = 0, AC = 1, AM = 2, AN = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [DW-1:0] mult;
  logic [LW-1:0] limit;
  logic          busy, done, error, we, re;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;

  always #2 clk = ~clk;  // 250 MHz

  pll_reprog_seq i_pll_reprog_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mult_i(mult),
    .lock_limit_i(limit), .busy_o(busy), .done_o(done), .error_o(error),
    .reg_we_o(we), .reg_re_o(re), .reg_addr_o(addr), .reg_wdata_o(wdata),
    .reg_rdata_i(rdata)
  );

  int vectors = 0;
  int miscompares = 0;

  // PLL register model with lock after a programmable number of polls.
  logic [DW-1:0] m_ctrl, m_mdiv, m_np;
  int            lock_after;
  int            polls;

  always @(posedge clk) begin
    if (we) begin
      case (addr)
        AC: begin m_ctrl <= wdata; polls <= 0; end
        AM: m_mdiv <= wdata;
        AN: m_np   <= wdata;
        default: ;
      endcase
    end
    if (re) begin
      if (addr == AS) begin
        rdata <= {31'b0, (!m_ctrl[0] && (polls >= lock_after))};
        polls <= polls + 1;
      end else if (addr == AC) rdata <= m_ctrl;
      else rdata <= '0;
    end
  end

  // Scoreboard queues.
  logic [AW+DW-1:0] exp_wr[$];
  string            exp_tag[$];
  bit               exp_err[$];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // Monitor: compare every write and every done against expectations.
  always @(negedge clk) begin
    if (rst_n && we) begin
      if (exp_wr.size() == 0)
        check(1'b0, "R7", {addr, wdata}, 0);
      else begin
        logic [AW+DW-1:0] e;
        string t;
        e = exp_wr.pop_front();
        t = exp_tag.pop_front();
        check({addr, wdata} == e, t, {addr, wdata}, e);
      end
    end
    if (rst_n && re && we) check(1'b0, "R8", {re, we}, 0);
    if (rst_n && done) begin
      if (exp_err.size() == 0) check(1'b0, "R7", done, 0);
      else begin
        bit ee;
        ee = exp_err.pop_front();
        check(error == ee, ee ? "R6" : "R5", error, ee);
      end
    end
  end

  task automatic run_seq(input logic [DW-1:0] c0, input logic [DW-1:0] m,
                         input int dly, input int lim, input bit disturb);
    logic [DW-1:0] iso, up;
    bit ok;
    ok  = dly < lim;
    iso = (c0 | 32'h1) & ~32'h1E;
    up  = iso & ~32'h1;
    exp_wr.push_back({AC, iso});               exp_tag.push_back("R2");
    exp_wr.push_back({AM, m});                 exp_tag.push_back("R3");
    exp_wr.push_back({AN, 32'h0030_2062});     exp_tag.push_back("R3");
    exp_wr.push_back({AC, up});                exp_tag.push_back("R4");
    if (ok) begin
      exp_wr.push_back({AC, up | 32'h10});     exp_tag.push_back("R5");
    end
    exp_err.push_back(!ok);
    m_ctrl = c0; lock_after = dly; limit = LW'(lim);
    start = 1'b1; mult = m;
    @(negedge clk);
    start = 1'b0; mult = ~m;
    check(busy == 1'b1, "R9", busy, 1);
    if (disturb) begin
      repeat (3) @(negedge clk);
      start = 1'b1; mult = 32'hDEAD_BEEF;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    check(busy == 1'b0, "R9", busy, 0);
    check(exp_wr.size() == 0, "R2", exp_wr.size(), 0);
    check(m_ctrl[4] == ok, ok ? "R5" : "R6", m_ctrl[4], ok);
    check(m_ctrl[0] == 1'b0, "R4", m_ctrl[0], 0);
    check(m_np == 32'h0030_2062 && m_mdiv == m, "R3", m_mdiv, m);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; mult = '0; limit = 16'd4;
    m_ctrl = '0; lock_after = 0;
    repeat (3) @(negedge clk);
    check({busy, done, error, we, re} == 5'b0, "R1", {busy, done, error, we, re}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, done, error, we, re} == 5'b0, "R1", {busy, done, error, we, re}, 0);

    run_seq(32'h0000_001E, 32'h0001_2345, 3, 8, 1'b0);   // R2 bits set before
    run_seq(32'hA5A5_0003, 32'h0001_8003, 0, 8, 1'b0);   // R2 upper bits kept
    run_seq(32'h0000_0010, 32'h0000_7777, 4, 5, 1'b0);   // R6 last allowed poll
    run_seq(32'h0000_0010, 32'h0000_7777, 5, 5, 1'b0);   // R6 one poll too late
    check(m_ctrl[4] == 1'b0, "R6", m_ctrl[4], 0);
    run_seq(32'hFFFF_FFFF, 32'h0002_0001, 1, 1, 1'b0);   // R6 limit of one
    run_seq(32'h1234_5608, 32'h0003_0303, 0, 1, 1'b0);   // R5 first poll locks
    run_seq(32'h0000_0000, 32'h0000_4242, 6, 20, 1'b1);  // R7 start while busy
    // R9: start again right after done, with no gap.
    run_seq(32'h0F0F_0F0F, 32'h0000_0001, 2, 3, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule